// File: doc/BRIEF.md
# Segment Display I2C Write Slave

This block is the write-only serial front end of a segment display controller. It watches the two bus lines, which it brings into its own clock domain first. It answers one fixed device address with the write direction and then sorts each transfer into one of two kinds. A command transfer carries an opcode and one setting byte, and the block hands both out on a one-cycle strobe. A display RAM transfer starts with a reserved opcode and a location byte, followed by any number of data bytes. The data bytes land in a 16-byte display memory at a pointer that steps forward after every byte.

The pointer wraps to zero after the last location of the active scan mode. A mode input picks either ten or sixteen locations. The display scan logic reads the memory through a separate combinational port. Reads from the bus and clock stretching are not supported.

Top module: `segdisp_i2c_wr`

## Requirements
- R1: The block acknowledges only the address byte 0x70 (device address 0111000 with direction bit 0). Any other address byte, including the read form 0x71, gets no acknowledge, and every byte up to the next START is then ignored with no acknowledge and no strobe.
- R2: Bits are taken MSB first on rising SCL. The acknowledge (`sda_oe_o` high) starts after the SCL falling edge that ends bit 0 and ends after the next SCL falling edge.
- R3: A command byte other than 0x80, followed by a setting byte, gives one `cmd_stb_o` pulse carrying both bytes. The pulse comes while SCL is high on the ninth clock of the setting byte.
- R4: A command byte of 0x80 makes the next byte a location byte that is loaded into the write pointer. Each later data byte is written into the display memory at the pointer.
- R5: After each data byte, on its ninth clock, the block raises `ram_we_o` for one cycle and then advances the pointer by one. Any number of data bytes may follow in one transfer.
- R6: With `duty8_i`=1 the pointer wraps from 15 to 0. With `duty8_i`=0 it wraps from 9 to 0.
- R7: A location byte above the active top location (9 or 15) loads the pointer with 0.
- R8: A START in the middle of a transfer drops any partial byte and starts address matching again.
- R9: After reset, `sda_oe_o`, `cmd_stb_o` and `ram_we_o` are low and every memory location reads 0.
- R10: `scan_data_o` shows the location at `scan_addr_i` with no register in the path. In the cycle where `ram_we_o` writes that location, the port still shows the old value; from the next cycle on it shows the new value.
- R11: After a command setting byte, further bytes in the same transfer get no acknowledge and no strobe. A STOP releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge) |
| duty8_i | input | 1 | 1: 16-location wrap, 0: 10-location wrap |
| cmd_stb_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 8 | Command opcode, valid with the strobe |
| cmd_set_o | output | 8 | Command setting, valid with the strobe |
| ram_we_o | output | 1 | Display memory write enable |
| ram_addr_o | output | 4 | Display memory write location |
| ram_data_o | output | 8 | Display memory write data |
| scan_addr_i | input | 4 | Scan read location |
| scan_data_o | output | 8 | Scan read data |

## Verification
Two things can meet in one cycle: a bus write into the display memory and a scan read of the same location. The bench provokes this by holding the scan address on a location that a page write is about to fill, including the location where the pointer wraps. Whenever the write strobe hits that location, the monitor checks that the scan port still shows the content the bench's model held before the write. Later reads must show the new byte.

// File: rtl/segi2c_pkg.sv
package segi2c_pkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_ADDR,
    PS_CMD,
    PS_SET,
    PS_REG,
    PS_DATA
  } pstate_e;

  // highest legal location for the selected scan mode
  function automatic int unsigned seg_top(input logic duty8,
                                          input int unsigned long_n,
                                          input int unsigned short_n);
    return duty8 ? (long_n - 1) : (short_n - 1);
  endfunction

  // pointer after one data byte
  function automatic int unsigned seg_step(input int unsigned p,
                                           input int unsigned top);
    return (p >= top) ? 0 : p + 1;
  endfunction

  // pointer value loaded from a location byte
  function automatic int unsigned seg_entry(input int unsigned a,
                                            input int unsigned top);
    return (a > top) ? 0 : a;
  endfunction

endpackage

// File: rtl/seg_i2c_lines.sv
module seg_i2c_lines (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lv_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_m, scl_s, scl_d;
  logic sda_m, sda_s, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_d <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= scl_i; scl_s <= scl_m; scl_d <= scl_s;
      sda_m <= sda_i; sda_s <= sda_m; sda_d <= sda_s;
    end
  end

  assign sda_lv_o   = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/seg_i2c_shift.sv
module seg_i2c_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_reset_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lv_i,
  input  logic          ack_want_i,
  output logic [BW-1:0] byte_o,
  output logic          byte_vld_o,
  output logic          ack_clk_o,
  output logic          sda_oe_o
);
  localparam int CW = $clog2(BW + 1);

  logic [CW-1:0] cnt_q;
  logic          in_ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; in_ack_q <= 1'b0; sda_oe_o <= 1'b0;
      byte_o <= '0; byte_vld_o <= 1'b0; ack_clk_o <= 1'b0;
    end else if (bus_reset_i) begin
      cnt_q <= '0; in_ack_q <= 1'b0; sda_oe_o <= 1'b0;
      byte_vld_o <= 1'b0; ack_clk_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      ack_clk_o  <= 1'b0;
      if (scl_rise_i && !in_ack_q && cnt_q < CW'(BW)) begin
        byte_o <= {byte_o[BW-2:0], sda_lv_i};
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == CW'(BW - 1)) byte_vld_o <= 1'b1;
      end
      if (scl_rise_i && in_ack_q) ack_clk_o <= 1'b1;
      if (scl_fall_i && !in_ack_q && cnt_q == CW'(BW)) begin
        in_ack_q <= 1'b1;
        sda_oe_o <= ack_want_i;
      end else if (scl_fall_i && in_ack_q) begin
        in_ack_q <= 1'b0;
        sda_oe_o <= 1'b0;
        cnt_q    <= '0;
      end
    end
  end
endmodule

// File: rtl/seg_frame_ctl.sv
module seg_frame_ctl
  import segi2c_pkg::*;
#(
  parameter int          BW       = 8,
  parameter int          AW       = 4,
  parameter int          DEPTH    = 16,
  parameter int          SHORT_N  = 10,
  parameter logic [6:0]  DEV_ADDR = 7'b0111000,
  parameter logic [7:0]  RAM_OP   = 8'h80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          byte_vld_i,
  input  logic [BW-1:0] byte_i,
  input  logic          ack_clk_i,
  input  logic          duty8_i,
  output logic          ack_want_o,
  output logic          cmd_stb_o,
  output logic [BW-1:0] cmd_code_o,
  output logic [BW-1:0] cmd_set_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [BW-1:0] wdata_o
);
  pstate_e       st_q;
  logic [AW-1:0] ptr_q;
  logic          pend_cmd_q, pend_wr_q;
  int unsigned   top;

  assign top = seg_top(duty8_i, DEPTH, SHORT_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PS_IDLE; ptr_q <= '0; ack_want_o <= 1'b0;
      pend_cmd_q <= 1'b0; pend_wr_q <= 1'b0;
      cmd_stb_o <= 1'b0; we_o <= 1'b0;
      cmd_code_o <= '0; cmd_set_o <= '0; waddr_o <= '0; wdata_o <= '0;
    end else begin
      cmd_stb_o <= 1'b0;
      we_o      <= 1'b0;
      if (start_i || stop_i) begin
        st_q       <= start_i ? PS_ADDR : PS_IDLE;
        ack_want_o <= 1'b0;
        pend_cmd_q <= 1'b0;
        pend_wr_q  <= 1'b0;
      end else begin
        if (byte_vld_i) begin
          ack_want_o <= 1'b1;
          case (st_q)
            PS_ADDR: begin
              if (byte_i == {DEV_ADDR, 1'b0}) st_q <= PS_CMD;
              else begin
                st_q <= PS_IDLE; ack_want_o <= 1'b0;
              end
            end
            PS_CMD: begin
              cmd_code_o <= byte_i;
              st_q       <= (byte_i == RAM_OP) ? PS_REG : PS_SET;
            end
            PS_SET: begin
              cmd_set_o  <= byte_i;
              pend_cmd_q <= 1'b1;
              st_q       <= PS_IDLE;
            end
            PS_REG: begin
              ptr_q <= AW'(seg_entry(32'(byte_i), top));
              st_q  <= PS_DATA;
            end
            PS_DATA: begin
              wdata_o   <= byte_i;
              pend_wr_q <= 1'b1;
            end
            default: ack_want_o <= 1'b0;
          endcase
        end
        if (ack_clk_i) begin
          if (pend_cmd_q) begin
            cmd_stb_o  <= 1'b1;
            pend_cmd_q <= 1'b0;
          end
          if (pend_wr_q) begin
            we_o      <= 1'b1;
            waddr_o   <= ptr_q;
            ptr_q     <= AW'(seg_step(32'(ptr_q), top));
            pend_wr_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/seg_dram.sv
module seg_dram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we_i) begin
      cell_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = cell_q[raddr_i];
endmodule

// File: rtl/segdisp_i2c_wr.sv
module segdisp_i2c_wr #(
  parameter int          DW       = 8,
  parameter int          DEPTH    = 16,
  parameter int          SHORT_N  = 10,
  parameter logic [6:0]  DEV_ADDR = 7'b0111000,
  parameter logic [7:0]  RAM_OP   = 8'h80,
  localparam int         AW       = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          duty8_i,
  output logic          cmd_stb_o,
  output logic [DW-1:0] cmd_code_o,
  output logic [DW-1:0] cmd_set_o,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_data_o,
  input  logic [AW-1:0] scan_addr_i,
  output logic [DW-1:0] scan_data_o
);
  // named internal events
  logic          sda_lv, scl_rise, scl_fall, start_p, stop_p;
  logic [DW-1:0] rx_byte;
  logic          byte_vld, ack_clk, ack_want;

  seg_i2c_lines u_lines (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_lv_o(sda_lv), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  seg_i2c_shift #(.BW(DW)) u_shift (
    .clk_i, .rst_ni,
    .bus_reset_i(start_p | stop_p),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_lv_i(sda_lv),
    .ack_want_i(ack_want),
    .byte_o(rx_byte), .byte_vld_o(byte_vld), .ack_clk_o(ack_clk),
    .sda_oe_o(sda_oe_o)
  );

  seg_frame_ctl #(
    .BW(DW), .AW(AW), .DEPTH(DEPTH), .SHORT_N(SHORT_N),
    .DEV_ADDR(DEV_ADDR), .RAM_OP(RAM_OP)
  ) u_frame (
    .clk_i, .rst_ni,
    .start_i(start_p), .stop_i(stop_p),
    .byte_vld_i(byte_vld), .byte_i(rx_byte), .ack_clk_i(ack_clk),
    .duty8_i,
    .ack_want_o(ack_want),
    .cmd_stb_o, .cmd_code_o, .cmd_set_o,
    .we_o(ram_we_o), .waddr_o(ram_addr_o), .wdata_o(ram_data_o)
  );

  seg_dram #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_dram (
    .clk_i, .rst_ni,
    .we_i(ram_we_o), .waddr_i(ram_addr_o), .wdata_i(ram_data_o),
    .raddr_i(scan_addr_i), .rdata_o(scan_data_o)
  );
endmodule

// File: rtl/segdisp_chk.sv
module segdisp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_fall,
  input logic start_p,
  input logic stop_p,
  input logic sda_oe_o,
  input logic cmd_stb_o,
  input logic ram_we_o
);
  // R2
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R2
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> $past(scl_fall || start_p || stop_p));

  // R3
  cmd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);

  // R5
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> !ram_we_o);

  // R4
  path_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_stb_o && ram_we_o));

  // R11
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_p |=> !sda_oe_o);
endmodule

bind segdisp_i2c_wr segdisp_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_fall(scl_fall),
  .start_p(start_p), .stop_p(stop_p), .sda_oe_o(sda_oe_o),
  .cmd_stb_o(cmd_stb_o), .ram_we_o(ram_we_o)
);

// File: tb/segdisp_i2c_wr_tb_top.sv
module segdisp_i2c_wr_tb_top;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, duty8 = 1'b1;
  logic [3:0] scan_addr = '0;
  logic sda_oe, cmd_stb, ram_we;
  logic [7:0] cmd_code, cmd_set, ram_data, scan_data;
  logic [3:0] ram_addr;
  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  segdisp_i2c_wr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .duty8_i(duty8),
    .cmd_stb_o(cmd_stb), .cmd_code_o(cmd_code), .cmd_set_o(cmd_set),
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_data_o(ram_data),
    .scan_addr_i(scan_addr), .scan_data_o(scan_data)
  );

  typedef struct { bit is_ram; logic [7:0] a; logic [7:0] d; } exp_t;
  exp_t expq[$];
  logic [7:0] model [16];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = !sda_bus;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic cmd_write(input logic [7:0] code, input logic [7:0] set);
    bit a;
    i2c_start();
    send_byte(8'h70, a); chk("R1 address ack", a, 1);
    send_byte(code, a);  chk("R2 command ack", a, 1);
    expq.push_back('{0, code, set});
    send_byte(set, a);   chk("R3 setting ack", a, 1);
    i2c_stop();
  endtask

  task automatic ram_page(input logic [7:0] loc, input logic [7:0] base, input int n);
    bit a;
    int unsigned top, p;
    top = duty8 ? 15 : 9;
    p = (loc > top) ? 0 : loc;
    i2c_start();
    send_byte(8'h70, a); chk("R1 address ack", a, 1);
    send_byte(8'h80, a); chk("R4 ram opcode ack", a, 1);
    send_byte(loc, a);   chk("R4 location ack", a, 1);
    for (int i = 0; i < n; i++) begin
      expq.push_back('{1, p[7:0], base + 8'(i * 7)});
      send_byte(base + 8'(i * 7), a); chk("R5 data ack", a, 1);
      p = (p >= top) ? 0 : p + 1;
    end
    i2c_stop();
  endtask

  task automatic read_chk(input logic [3:0] ad, input string req);
    scan_addr = ad; tick(1);
    chk(req, scan_data, model[ad]);
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (rst_n && (cmd_stb || ram_we)) begin
      if (expq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R1 unexpected strobe actual=%0h expected=0", {cmd_stb, ram_we});
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk("R3/R4 path kind", ram_we, e.is_ram);
        chk("R3/R5 ninth clock high", scl_m, 1);
        if (e.is_ram) begin
          chk("R5 write location", ram_addr, e.a);
          chk("R4 write data", ram_data, e.d);
          if (scan_addr == ram_addr) chk("R10 old value in write cycle", scan_data, model[ram_addr]);
          model[e.a[3:0]] = e.d;
        end else begin
          chk("R3 command code", cmd_code, e.a);
          chk("R3 command setting", cmd_set, e.d);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < 16; i++) model[i] = '0;
    tick(4); rst_n = 1'b1; tick(4);
    // R9 reset state
    chk("R9 sda released", sda_oe, 0);
    chk("R9 no command strobe", cmd_stb, 0);
    chk("R9 no write strobe", ram_we, 0);
    read_chk(4'd5, "R9 memory clear");

    // R3 command pairs, R2 MSB-first values
    cmd_write(8'h34, 8'hA5);
    cmd_write(8'hE0, 8'h01);

    // R1 wrong address, then read direction
    i2c_start();
    send_byte(8'h72, a); chk("R1 foreign address nack", a, 0);
    send_byte(8'h34, a); chk("R1 ignored byte nack", a, 0);
    send_byte(8'h55, a); chk("R1 ignored byte nack", a, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'h71, a); chk("R1 read direction nack", a, 0);
    send_byte(8'h80, a); chk("R1 ignored byte nack", a, 0);
    i2c_stop();

    // R4 single byte, scan port parked on it (R10)
    scan_addr = 4'd3;
    ram_page(8'd3, 8'h5A, 1);
    read_chk(4'd3, "R10 new value visible");

    // R6 wrap at 15 in 16-location mode, scan parked on wrap target
    scan_addr = 4'd0;
    ram_page(8'd13, 8'h10, 6);
    for (int i = 0; i < 3; i++) read_chk(4'(i), "R6 wrapped locations");
    read_chk(4'd15, "R5 last location");

    // R6 wrap at 9 in 10-location mode
    duty8 = 1'b0;
    scan_addr = 4'd8;
    ram_page(8'd7, 8'hC1, 5);
    read_chk(4'd9, "R6 short top location");
    read_chk(4'd1, "R6 short wrapped location");
    read_chk(4'd10, "R6 location 10 untouched");

    // R7 location above the top loads 0
    ram_page(8'd12, 8'h77, 1);
    read_chk(4'd0, "R7 short mode clip");
    read_chk(4'd12, "R7 location 12 untouched");
    duty8 = 1'b1;
    ram_page(8'h20, 8'h99, 2);
    read_chk(4'd1, "R7 long mode clip");

    // R8 restart inside a partial byte
    i2c_start();
    send_bits(8'hFF, 5);
    cmd_write(8'h42, 8'h24);
    // R8 restart inside a partial data byte: nothing written
    i2c_start();
    send_byte(8'h70, a); chk("R8 address ack", a, 1);
    send_byte(8'h80, a); chk("R8 opcode ack", a, 1);
    send_byte(8'd4, a);  chk("R8 location ack", a, 1);
    send_bits(8'hEE, 3);
    cmd_write(8'h43, 8'h25);
    read_chk(4'd4, "R8 partial data dropped");

    // R11 extra byte after setting
    i2c_start();
    send_byte(8'h70, a); chk("R1 address ack", a, 1);
    send_byte(8'h11, a); chk("R3 command ack", a, 1);
    expq.push_back('{0, 8'h11, 8'h22});
    send_byte(8'h22, a); chk("R3 setting ack", a, 1);
    send_byte(8'h33, a); chk("R11 extra byte nack", a, 0);
    i2c_stop();
    chk("R11 sda released after stop", sda_oe, 0);

    tick(20);
    chk("R3/R5 all expected strobes seen", expq.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule